// File: doc/BRIEF.md
# Serial Byte Transmitter with Flow Control

This block serialises bytes onto a single asynchronous transmit line. A byte enters through a valid/ready handshake into a one-byte holding register. From there it moves into a shift register, so one byte can wait while another is on the wire. The frame has a low start bit, then 7 or 8 data bits sent least significant bit first, an optional parity bit of one of four kinds, and one or two high stop bits. The bit period is set by a 16-bit divisor.

Two kinds of flow control can stop a new frame from starting. A frame that is already on the line is never cut short by either of them.
- When clear-to-send gating is enabled, the active-low clear-to-send input must be low before a frame starts.
- An XOFF pause is set by a one-cycle pulse from a receiver and stays set until an explicit clear strobe.

An optional automatic request-to-send output (active low) is driven low before the first start bit. It stays low for a programmable number of half-character times after the last stop bit. When the transmitter is disabled, the line rests at a static level taken from an input.

Top module: `uart_tx_fc`

## Requirements
- R1: A frame starts with a 0 start bit, sends data least significant bit first and ends with stop bits at 1. Every bit lasts `bit_div`+1 clock cycles, and a `bit_div` of 0 behaves as 1, giving 2 cycles per bit. Between frames the enabled line is 1.
- R2: `len7`=0 sends 8 data bits. `len7`=1 sends the low 7 bits of the byte, and bit 7 is not sent.
- R3: When `par_on`=1, one parity bit follows the data bits. When `par_on`=0, no parity bit is sent. `par_kind` selects the parity bit:
  - 0: even, so the data bits plus the parity bit hold an even number of ones.
  - 1: odd.
  - 2: mark, always 1.
  - 3: space, always 0.
- R4: `stop2`=0 sends one stop bit and `stop2`=1 sends two.
- R5: `in_ready` is high when the holding register is empty or is being moved into the shifter in the same cycle. A byte is taken on a clock edge where `in_valid` and `in_ready` are both high. `hold_empty` is high when no byte waits in the holding register. `line_idle` goes high in the cycle after the last stop bit ends and stays high until the next frame starts.
- R6: When `cts_gate`=1 and `cts_n`=1, no frame starts. A frame that has already started runs to its end even if `cts_n` rises during it.
- R7: When `rts_auto`=1, `rts_n` goes low one cycle before the start bit. `rts_n` returns high (`rts_code`+1)×5 bit periods after the last stop bit ends, so one code step is half of a ten-bit character. A frame that starts within that window keeps `rts_n` low. When `rts_auto`=0, `rts_n` is 1.
- R8: When `enable`=0, `txd` equals `rest_level`, any frame in progress is dropped and `line_idle` is 1 from the next cycle on.
- R9: A pulse on `xoff_set` sets `xoff_paused`, and `xoff_clr` clears it. Clear wins when both arrive in the same cycle. While `xoff_paused`=1 no new frame starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Transmitter enable |
| rest_level | input | 1 | Line level while disabled |
| bit_div | input | 16 | Bit period divisor (period = max(bit_div,1)+1 cycles) |
| len7 | input | 1 | 1 = 7 data bits, 0 = 8 |
| par_on | input | 1 | Send a parity bit |
| par_kind | input | 2 | 0 even, 1 odd, 2 mark, 3 space |
| stop2 | input | 1 | 1 = two stop bits |
| cts_gate | input | 1 | Gate frame starts on clear-to-send |
| cts_n | input | 1 | Clear-to-send, active low |
| rts_auto | input | 1 | Drive request-to-send automatically |
| rts_code | input | 3 | Request-to-send hold, (code+1) half characters |
| xoff_set | input | 1 | Pulse that starts an XOFF pause |
| xoff_clr | input | 1 | Strobe that ends an XOFF pause |
| in_data | input | 8 | Byte to send |
| in_valid | input | 1 | `in_data` is valid |
| in_ready | output | 1 | A byte can be taken |
| txd | output | 1 | Serial output line |
| rts_n | output | 1 | Request-to-send, active low |
| hold_empty | output | 1 | No byte waits in the holding register |
| line_idle | output | 1 | Shifter has finished its last stop bit |
| xoff_paused | output | 1 | XOFF pause in force |

## Verification
On every cycle, the assertions check the following:
- a frame never starts while clear-to-send blocks it or an XOFF pause is held;
- each frame opens with a low start bit;
- request-to-send is already low at the start bit;
- an accepted byte fills the holding register;
- disabling the transmitter returns it to idle.

Some behaviours can only be shown by the bench's scenarios:
- the exact bit sequence for each data-length, parity and stop-bit setting;
- the exact bit duration, including the zero-divisor case;
- the queueing of a second byte behind a busy frame;
- the exact cycle at which request-to-send is released after the hold window.

// File: rtl/uart_tx_fc.sv
module uart_tx_fc #(
  parameter int DIV_W  = 16,
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              rest_level,
  input  logic [DIV_W-1:0]  bit_div,
  input  logic              len7,
  input  logic              par_on,
  input  logic [1:0]        par_kind,
  input  logic              stop2,
  input  logic              cts_gate,
  input  logic              cts_n,
  input  logic              rts_auto,
  input  logic [CODE_W-1:0] rts_code,
  input  logic              xoff_set,
  input  logic              xoff_clr,
  input  logic [7:0]        in_data,
  input  logic              in_valid,
  output logic              in_ready,
  output logic              txd,
  output logic              rts_n,
  output logic              hold_empty,
  output logic              line_idle,
  output logic              xoff_paused
);
  localparam int FW = 12;
  localparam int RW = DIV_W + CODE_W + 5;

  logic              hold_full;
  logic [7:0]        hold_q;
  logic              busy;
  logic [FW-1:0]     sh;
  logic [3:0]        left;
  logic [DIV_W-1:0]  cnt;
  logic              rts_q;
  logic [RW-1:0]     rts_left;
  logic              paused;
  logic              pbit;
  logic [FW-1:0]     frame;

  wire [DIV_W-1:0] last   = (bit_div == '0) ? DIV_W'(1) : bit_div;
  wire             tick   = busy && (cnt == last);
  wire             fin    = tick && (left == 4'd1);
  wire             cts_ok = !cts_gate || !cts_n;
  wire             may_go = enable && hold_full && !busy && !paused && cts_ok;
  wire             start  = may_go && (!rts_auto || !rts_q);
  wire             dxor   = len7 ? ^hold_q[6:0] : ^hold_q;
  wire [3:0]       nbits  = 4'd1 + (len7 ? 4'd7 : 4'd8) + {3'b000, par_on} + (stop2 ? 4'd2 : 4'd1);
  wire [RW-1:0]    hold_cycles = (RW'(rts_code) + RW'(1)) * RW'(5) * (RW'(last) + RW'(1));

  always_comb begin
    case (par_kind)
      2'd0:    pbit = dxor;
      2'd1:    pbit = ~dxor;
      2'd2:    pbit = 1'b1;
      default: pbit = 1'b0;
    endcase
    frame    = '1;
    frame[0] = 1'b0;
    if (len7) begin
      frame[7:1] = hold_q[6:0];
      if (par_on) frame[8] = pbit;
    end else begin
      frame[8:1] = hold_q;
      if (par_on) frame[9] = pbit;
    end
  end

  assign in_ready    = !hold_full || start;
  assign hold_empty  = !hold_full;
  assign line_idle   = !busy;
  assign xoff_paused = paused;
  assign rts_n       = rts_auto ? rts_q : 1'b1;
  assign txd         = enable ? (busy ? sh[0] : 1'b1) : rest_level;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_full <= 1'b0;
      hold_q    <= '0;
      busy      <= 1'b0;
      sh        <= '1;
      left      <= '0;
      cnt       <= '0;
      rts_q     <= 1'b1;
      rts_left  <= '0;
      paused    <= 1'b0;
    end else begin
      if (start) hold_full <= 1'b0;
      if (in_valid && in_ready) begin
        hold_full <= 1'b1;
        hold_q    <= in_data;
      end

      if (xoff_clr)      paused <= 1'b0;
      else if (xoff_set) paused <= 1'b1;

      if (!enable) begin
        busy <= 1'b0;
        cnt  <= '0;
      end else if (start) begin
        busy <= 1'b1;
        sh   <= frame;
        left <= nbits;
        cnt  <= '0;
      end else if (tick) begin
        cnt  <= '0;
        sh   <= {1'b1, sh[FW-1:1]};
        left <= left - 4'd1;
        if (left == 4'd1) busy <= 1'b0;
      end else if (busy) begin
        cnt <= cnt + DIV_W'(1);
      end

      if (!enable || !rts_auto) begin
        rts_q    <= 1'b1;
        rts_left <= '0;
      end else begin
        if (may_go && rts_q) rts_q <= 1'b0;
        if (start) rts_left <= '0;
        else if (fin) rts_left <= hold_cycles;
        else if (rts_left != '0) begin
          rts_left <= rts_left - RW'(1);
          if (rts_left == RW'(1)) rts_q <= 1'b1;
        end
      end
    end
  end

  a_r1_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && $rose(busy)) |-> !txd);
  a_r6_cts_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (cts_gate && cts_n && !busy) |=> !busy);
  a_r9_xoff_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (paused && !busy) |=> !busy);
  a_r7_rts_before_start: assert property (@(posedge clk) disable iff (!rst_n)
    (rts_auto && $past(rts_auto) && $past(enable) && $rose(busy)) |-> !rts_n);
  a_r5_accept_fills: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !hold_empty);
  a_r8_disable_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> line_idle);
endmodule

// File: tb/uart_tx_fc_test.sv
module uart_tx_fc_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0, rest_level = 1'b1;
  logic [15:0] bit_div = 16'd1;
  logic len7 = 1'b0, par_on = 1'b0, stop2 = 1'b0;
  logic [1:0] par_kind = 2'd0;
  logic cts_gate = 1'b0, cts_n = 1'b0, rts_auto = 1'b0;
  logic [2:0] rts_code = 3'd0;
  logic xoff_set = 1'b0, xoff_clr = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic in_valid = 1'b0;
  logic in_ready, txd, rts_n, hold_empty, line_idle, xoff_paused;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  uart_tx_fc uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .rest_level(rest_level),
    .bit_div(bit_div), .len7(len7), .par_on(par_on), .par_kind(par_kind),
    .stop2(stop2), .cts_gate(cts_gate), .cts_n(cts_n), .rts_auto(rts_auto),
    .rts_code(rts_code), .xoff_set(xoff_set), .xoff_clr(xoff_clr),
    .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready), .txd(txd),
    .rts_n(rts_n), .hold_empty(hold_empty), .line_idle(line_idle),
    .xoff_paused(xoff_paused)
  );

  // fields: data[31:24] len7[23] par_on[22] par_kind[21:20] stop2[19] div[18:16] nbits[15:12] frame[11:0]
  localparam logic [31:0] VEC [8] = '{
    {8'hA5, 1'b0, 1'b0, 2'd0, 1'b0, 3'd3, 4'd10, 12'hF4A},
    {8'h3C, 1'b0, 1'b1, 2'd0, 1'b0, 3'd0, 4'd11, 12'hC78},
    {8'h3C, 1'b0, 1'b1, 2'd1, 1'b1, 3'd1, 4'd12, 12'hE78},
    {8'hC1, 1'b1, 1'b1, 2'd2, 1'b0, 3'd2, 4'd10, 12'hF82},
    {8'h7F, 1'b1, 1'b1, 2'd3, 1'b1, 3'd3, 4'd11, 12'hEFE},
    {8'h80, 1'b1, 1'b0, 2'd0, 1'b0, 3'd1, 4'd9,  12'hF00},
    {8'h01, 1'b0, 1'b1, 2'd0, 1'b0, 3'd2, 4'd11, 12'hE02},
    {8'h01, 1'b0, 1'b1, 2'd1, 1'b0, 3'd2, 4'd11, 12'hC02}
  };

  task automatic check(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] d);
    @(negedge clk);
    in_data  = d;
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic wait_start();
    int n = 0;
    while (line_idle && n < 2000) begin @(negedge clk); n++; end
  endtask

  task automatic check_frame(input logic [11:0] exp, input int n, input int p, input string what);
    int bad = 0;
    logic [11:0] seen = '1;
    wait_start();
    for (int k = 0; k < n; k++) begin
      if (txd !== exp[k]) bad++;
      seen[k] = txd;
      repeat (p - 1) @(negedge clk);
      if (txd !== exp[k]) bad++;
      @(negedge clk);
    end
    check(bad == 0, what, int'(seen), int'(exp));
    check(line_idle === 1'b1, "R5 line_idle after last stop bit", line_idle, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(txd === 1'b1 && in_ready === 1'b1 && hold_empty === 1'b1 && line_idle === 1'b1
          && rts_n === 1'b1 && xoff_paused === 1'b0, "reset state R5",
          {txd, in_ready, hold_empty, line_idle, rts_n, xoff_paused}, 6'b111110);
    rst_n = 1'b1;
    @(negedge clk);
    rest_level = 1'b0;
    @(negedge clk);
    check(txd === 1'b0, "R8 disabled line follows rest_level=0", txd, 0);
    rest_level = 1'b1;
    @(negedge clk);
    check(txd === 1'b1, "R8 disabled line follows rest_level=1", txd, 1);
    enable = 1'b1;

    // R1 R2 R3 R4 frame table
    foreach (VEC[i]) begin
      len7     = VEC[i][23];
      par_on   = VEC[i][22];
      par_kind = VEC[i][21:20];
      stop2    = VEC[i][19];
      bit_div  = {13'd0, VEC[i][18:16]};
      send_byte(VEC[i][31:24]);
      check_frame(VEC[i][11:0], int'(VEC[i][15:12]),
                  (VEC[i][18:16] == 3'd0) ? 2 : int'(VEC[i][18:16]) + 1,
                  $sformatf("R1/R2/R3/R4 frame vector %0d", i));
      @(negedge clk);
    end

    // R5 queueing behind a busy frame
    len7 = 1'b0; par_on = 1'b0; stop2 = 1'b0; bit_div = 16'd1;
    send_byte(8'h55);
    wait_start();
    send_byte(8'h0F);
    check(hold_empty === 1'b0 && in_ready === 1'b0, "R5 second byte waits in holding register",
          {hold_empty, in_ready}, 2'b00);
    while (!line_idle) @(negedge clk);
    check_frame(12'hE1E, 10, 2, "R5 queued byte frame");
    check(hold_empty === 1'b1 && in_ready === 1'b1, "R5 holding register drained",
          {hold_empty, in_ready}, 2'b11);

    // R6 clear-to-send gating
    cts_gate = 1'b1; cts_n = 1'b1;
    send_byte(8'h33);
    repeat (30) @(negedge clk);
    check(line_idle === 1'b1 && hold_empty === 1'b0, "R6 no start while cts_n high",
          {line_idle, hold_empty}, 2'b10);
    cts_n = 1'b0;
    wait_start();
    cts_n = 1'b1;
    repeat (19) @(negedge clk);
    check(line_idle === 1'b0, "R6 frame in progress keeps running", line_idle, 0);
    @(negedge clk);
    check(line_idle === 1'b1, "R6 frame ends on time", line_idle, 1);
    cts_gate = 1'b0; cts_n = 1'b0;

    // R9 XOFF pause
    @(negedge clk); xoff_set = 1'b1;
    @(negedge clk); xoff_set = 1'b0;
    check(xoff_paused === 1'b1, "R9 pause set", xoff_paused, 1);
    send_byte(8'h96);
    repeat (30) @(negedge clk);
    check(line_idle === 1'b1 && xoff_paused === 1'b1, "R9 no start while paused",
          {line_idle, xoff_paused}, 2'b11);
    xoff_set = 1'b1; xoff_clr = 1'b1;
    @(negedge clk); xoff_set = 1'b0; xoff_clr = 1'b0;
    check(xoff_paused === 1'b0, "R9 clear wins over set", xoff_paused, 0);
    check_frame(12'hF2C, 10, 2, "R9 frame after clear");

    // R7 automatic request-to-send
    rts_auto = 1'b1; rts_code = 3'd2;
    @(negedge clk);
    check(rts_n === 1'b1, "R7 rts_n high while nothing to send", rts_n, 1);
    send_byte(8'hA5);
    @(negedge clk);
    check(rts_n === 1'b0 && line_idle === 1'b1, "R7 rts_n low before start bit",
          {rts_n, line_idle}, 2'b01);
    check_frame(12'hF4A, 10, 2, "R7 frame under auto rts");
    check(rts_n === 1'b0, "R7 rts_n held after last stop bit", rts_n, 0);
    repeat (29) @(negedge clk);
    check(rts_n === 1'b0, "R7 rts_n held through hold window", rts_n, 0);
    @(negedge clk);
    check(rts_n === 1'b1, "R7 rts_n released after 3 half characters", rts_n, 1);
    rts_auto = 1'b0;

    // R8 disable drops a frame in progress
    send_byte(8'h00);
    wait_start();
    repeat (3) @(negedge clk);
    enable = 1'b0; rest_level = 1'b0;
    @(negedge clk);
    check(line_idle === 1'b1 && txd === 1'b0, "R8 disable drops frame, line at rest_level",
          {line_idle, txd}, 2'b10);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule